// File: doc/BRIEF.md
# Dual-Field Word-Serial Montgomery Multiplier

This block computes a Montgomery product one 32-bit word at a time. Its operands are S words long. Three operands are stored inside it: the multiplicand A, the multiplier B and the odd modulus N, together with one word of precomputed reduction constant. They are written word by word over a 32-bit load port. A one-cycle start pulse runs a column-ordered product scan. The scan goes over the 2S result columns, lowest first. Each column feeds a three-word accumulator, which drops one word at the end of the column. During the lower S columns the block derives the reduction digits m_i itself and keeps them.

A field select picks the arithmetic. Prime-field mode uses integer arithmetic with carries and ends with one conditional subtraction of N. Binary-field mode uses carry-less (XOR) arithmetic over polynomials and has no final subtraction. A square select tells the controller that B holds the same value as A. In that case each off-diagonal word product is taken once, doubled, and only the reduction term is fetched at the mirrored position. This shortens the run.

Top module: `dfmont_mul`

## Requirements
- R1: While `ld_en` is high at a clock edge, `ld_data` is written into the store chosen by `ld_sel`: 0 selects A, 1 selects B, 2 selects N, and 3 selects the reduction constant. The constant takes no address. For A, B and N, word k at `ld_addr` = k holds operand bits 32k+31 down to 32k, and words may be written in any order.
- R2: After reset, `busy`, `done` and `result` are all zero. A `start` pulse while idle clears `done` at that edge and raises `busy`. At the end of the run `busy` falls and `done` rises together, and `done` stays high until the next accepted start. `busy` and `done` are never high together.
- R3: With `field` = 0, an odd N, A < N, B < N and a constant equal to -N^(-1) mod 2^32, the `result` R satisfies R * 2^(32S) ≡ A * B (mod N) and R < N.
- R4: With `field` = 1, N's lowest bit set and a constant equal to N^(-1) mod x^32 (carry-less), `result` R satisfies R * x^(32S) ≡ A * B (mod N) as GF(2) polynomials. The accumulator never carries above its two low words, and no final subtraction is applied.
- R5: In multiply mode (`square` = 0), `done` rises exactly 2S^2 + 2S + 1 clock edges after the edge that samples `start`. For S = 4 that is 41 edges.
- R6: In square mode (`square` = 1, with B loaded equal to A), the result satisfies R3 or R4 for the selected field, and `done` rises in fewer edges than the multiply-mode count.
- R7: The prime-field result is fully reduced even when the scan leaves a word above the S result words, for example when N = 2^(32S) - 1 and the operands are close to N.
- R8: `field` and `square` are captured at the edge that samples `start`. Changing them during a run does not alter the result or the run length.
- R9: When each lower column closes, adding m_i * n_0 clears the accumulator's low word before the one-word shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Write enable of the load port |
| ld_sel | input | 2 | Target store: 0 A, 1 B, 2 N, 3 reduction constant |
| ld_addr | input | max(1, clog2(S)) | Word index inside the chosen operand |
| ld_data | input | 32 | Word being loaded |
| start | input | 1 | One-cycle request to begin a product |
| field | input | 1 | 0 integer (prime) arithmetic, 1 carry-less (binary) arithmetic |
| square | input | 1 | 1 when B equals A; enables the mirrored-product shortcut |
| busy | output | 1 | High while a product is in progress |
| done | output | 1 | High from completion until the next start |
| result | output | 32*S | Montgomery product, word k in bits 32k+31 down to 32k |

## Verification
The hardest case to reach from the ports is a prime-field run whose scan leaves a nonzero word above the S result words, so that the final subtraction is forced by that carry and not by the comparison. The stimulus gets there with the all-ones modulus and operands one or two below it, in both multiply and square mode. The mirrored-product path only proves itself when the doubled terms differ from the single ones. For that reason square runs use operands with distinct, dense words, and they are done in both fields: in the binary field the doubled terms must cancel. Holding the mode inputs is shown by flipping both mode inputs partway through a run.

// File: rtl/dfm_pkg.sv
`timescale 1ns/1ps
package dfm_pkg;

    localparam int W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STEP,
        ST_MCALC,
        ST_SHIFT1,
        ST_COL2,
        ST_FIX
    } dfm_state_e;

    function automatic logic [2*W-1:0] clmul_w(input logic [W-1:0] x, input logic [W-1:0] y);
        logic [2*W-1:0] p;
        p = '0;
        for (int b = 0; b < W; b++) begin
            if (y[b]) p = p ^ ({{W{1'b0}}, x} << b);
        end
        return p;
    endfunction

endpackage

// File: rtl/dfm_opstore.sv
`timescale 1ns/1ps
module dfm_opstore
    import dfm_pkg::*;
#(
    parameter int S  = 4,
    parameter int AW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [1:0]     wr_sel,
    input  logic [AW-1:0]  wr_addr,
    input  logic [W-1:0]   wr_data,
    output logic [S*W-1:0] a_vec,
    output logic [S*W-1:0] b_vec,
    output logic [S*W-1:0] n_vec,
    output logic [W-1:0]   kconst
);

    logic [S*W-1:0] a_d, a_q, b_d, b_q, n_d, n_q;
    logic [W-1:0]   k_d, k_q;

    always_comb begin
        a_d = a_q;
        b_d = b_q;
        n_d = n_q;
        k_d = k_q;
        if (wr_en) begin
            if (wr_sel == 2'd3) begin
                k_d = wr_data;
            end else if (int'(wr_addr) < S) begin
                case (wr_sel)
                    2'd0:    a_d[wr_addr*W +: W] = wr_data;
                    2'd1:    b_d[wr_addr*W +: W] = wr_data;
                    default: n_d[wr_addr*W +: W] = wr_data;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
            n_q <= '0;
            k_q <= '0;
        end else begin
            a_q <= a_d;
            b_q <= b_d;
            n_q <= n_d;
            k_q <= k_d;
        end
    end

    assign a_vec  = a_q;
    assign b_vec  = b_q;
    assign n_vec  = n_q;
    assign kconst = k_q;

endmodule

// File: rtl/dfm_mac.sv
`timescale 1ns/1ps
module dfm_mac
    import dfm_pkg::*;
(
    input  logic [3*W-1:0] acc_in,
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    input  logic           dbl,
    input  logic           vld,
    input  logic           bin,
    output logic [3*W-1:0] sum
);

    logic [2*W-1:0] p_int;
    logic [2*W-1:0] p_cl;
    logic [3*W-1:0] term;

    always_comb begin
        p_int = {{W{1'b0}}, x} * {{W{1'b0}}, y};
        p_cl  = clmul_w(x, y);
        if (!vld) begin
            term = '0;
        end else if (bin) begin
            // a doubled product is zero in characteristic two
            term = dbl ? '0 : {{W{1'b0}}, p_cl};
        end else begin
            term = dbl ? {{(W-1){1'b0}}, p_int, 1'b0} : {{W{1'b0}}, p_int};
        end
        sum = bin ? (acc_in ^ term) : (acc_in + term);
    end

endmodule

// File: rtl/dfm_reduce.sv
`timescale 1ns/1ps
module dfm_reduce
    import dfm_pkg::*;
#(
    parameter int S = 4
) (
    input  logic [S*W-1:0] r_in,
    input  logic [W-1:0]   high_word,
    input  logic [S*W-1:0] n_in,
    input  logic           prime,
    output logic [S*W-1:0] r_out
);

    logic need_sub;

    always_comb begin
        need_sub = prime && ((high_word != '0) || (r_in >= n_in));
        r_out    = need_sub ? (r_in - n_in) : r_in;
    end

endmodule

// File: rtl/dfmont_mul.sv
`timescale 1ns/1ps
module dfmont_mul
    import dfm_pkg::*;
#(
    parameter int S = 4,
    parameter int AW = (S > 1) ? $clog2(S) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ld_en,
    input  logic [1:0]     ld_sel,
    input  logic [AW-1:0]  ld_addr,
    input  logic [W-1:0]   ld_data,
    input  logic           start,
    input  logic           field,
    input  logic           square,
    output logic           busy,
    output logic           done,
    output logic [S*W-1:0] result
);

    localparam int IW = $clog2(2 * S) + 1;
    localparam logic [IW-1:0] S_I   = IW'(S);
    localparam logic [IW-1:0] LAST2 = IW'(2 * S - 1);
    localparam logic [IW-1:0] END2  = IW'(2 * S);
    localparam logic [IW-1:0] ONE   = IW'(1);

    typedef struct packed {
        dfm_state_e     state;
        logic [IW-1:0]  i;
        logic [IW-1:0]  j;
        logic           ph;
        logic           fld;
        logic           sq;
        logic [3*W-1:0] acc;
        logic [W-1:0]   opx;
        logic [W-1:0]   opy;
        logic           dbl;
        logic           opv;
        logic [S*W-1:0] m;
        logic [S*W-1:0] r;
        logic           done;
    } ctl_t;

    ctl_t cq, cd;

    logic [S*W-1:0] a_vec, b_vec, n_vec, r_fixed;
    logic [W-1:0]   kconst, mval;
    logic [3*W-1:0] mac_sum;
    logic [IW-1:0]  k, ni;

    function automatic logic [W-1:0] wsel(input logic [S*W-1:0] v, input logic [IW-1:0] idx);
        return v[idx*W +: W];
    endfunction

    dfm_opstore #(.S(S), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(ld_en), .wr_sel(ld_sel),
        .wr_addr(ld_addr), .wr_data(ld_data),
        .a_vec(a_vec), .b_vec(b_vec), .n_vec(n_vec), .kconst(kconst)
    );

    dfm_mac u_mac (
        .acc_in(cq.acc), .x(cq.opx), .y(cq.opy), .dbl(cq.dbl),
        .vld(cq.opv), .bin(cq.fld), .sum(mac_sum)
    );

    dfm_reduce #(.S(S)) u_reduce (
        .r_in(cq.r), .high_word(cq.acc[W-1:0]), .n_in(n_vec),
        .prime(!cq.fld), .r_out(r_fixed)
    );

    always_comb begin
        cd     = cq;
        cd.opv = 1'b0;
        cd.dbl = 1'b0;
        k      = cq.i - cq.j;
        ni     = cq.i + ONE;
        mval   = cq.fld ? clmul_w(mac_sum[W-1:0], kconst)[W-1:0]
                        : mac_sum[W-1:0] * kconst;
        case (cq.state)
            ST_IDLE: begin
                if (start) begin
                    cd.state = ST_STEP;
                    cd.i     = '0;
                    cd.j     = '0;
                    cd.ph    = 1'b0;
                    cd.fld   = field;
                    cd.sq    = square;
                    cd.acc   = '0;
                    cd.done  = 1'b0;
                end
            end
            ST_STEP: begin
                cd.acc = mac_sum;
                cd.opv = 1'b1;
                if (cq.i < S_I && cq.j == cq.i) begin
                    // closing slot of a lower column: a_i * b_0
                    cd.opx   = wsel(a_vec, cq.i);
                    cd.opy   = wsel(b_vec, '0);
                    cd.state = ST_MCALC;
                end else if (!cq.ph && !(cq.sq && cq.j > k)) begin
                    cd.opx = wsel(a_vec, cq.j);
                    cd.opy = wsel(b_vec, k);
                    cd.dbl = cq.sq && (cq.j < k);
                    cd.ph  = 1'b1;
                end else begin
                    cd.opx = wsel(cd.m, cq.j);
                    cd.opy = wsel(n_vec, k);
                    cd.ph  = 1'b0;
                    cd.j   = cq.j + ONE;
                    if (cq.i < S_I) begin
                        // in square mode a_i * b_0 was already taken as 2 * a_0 * b_i
                        if (cq.sq && (cq.j + ONE) == cq.i) cd.state = ST_MCALC;
                    end else if (cq.j == S_I - ONE) begin
                        cd.state = ST_COL2;
                    end
                end
            end
            ST_MCALC: begin
                cd.acc                = mac_sum;
                cd.m[cq.i*W +: W]     = mval;
                cd.opx                = mval;
                cd.opy                = wsel(n_vec, '0);
                cd.opv                = 1'b1;
                cd.state              = ST_SHIFT1;
            end
            ST_SHIFT1, ST_COL2: begin
                cd.acc = mac_sum >> W;
                cd.i   = ni;
                cd.ph  = 1'b0;
                if (cq.state == ST_COL2) cd.r[(cq.i - S_I)*W +: W] = mac_sum[W-1:0];
                if (ni < S_I) begin
                    cd.j     = '0;
                    cd.state = ST_STEP;
                end else if (ni == END2) begin
                    cd.state = ST_FIX;
                end else if (ni == LAST2) begin
                    cd.state = ST_COL2;
                end else begin
                    cd.j     = ni - S_I + ONE;
                    cd.state = ST_STEP;
                end
            end
            ST_FIX: begin
                cd.r     = r_fixed;
                cd.done  = 1'b1;
                cd.state = ST_IDLE;
            end
            default: cd.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cq       <= '0;
            cq.state <= ST_IDLE;
        end else begin
            cq <= cd;
        end
    end

    assign busy   = (cq.state != ST_IDLE);
    assign done   = cq.done;
    assign result = cq.r;

    // R2: completion flag and activity never overlap
    a_r2_busy_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R9: the reduction digit clears the low word before each lower-column shift
    a_r9_low_word_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (cq.state == ST_SHIFT1) |-> (mac_sum[W-1:0] == '0));

    // R4: carry-less accumulation never reaches the top word
    a_r4_binary_carry_free: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cq.fld) |-> (cq.acc[3*W-1:2*W] == '0));

    // R3: a finished prime-field result lies below the modulus
    a_r3_result_reduced: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) && !cq.fld) |-> (result < n_vec));

    // R8: captured mode bits stay fixed for the whole run
    a_r8_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(cq.fld) && $stable(cq.sq)));

endmodule

// File: tb/dfmont_mul_bench.sv
`timescale 1ns/1ps
module dfmont_mul_bench;

    localparam int CLK_PERIOD = 10;
    localparam int S  = 4;
    localparam int AW = 2;
    localparam int NB = 32 * S;
    localparam int MUL_CYC = 2 * S * S + 2 * S + 1;

    typedef struct packed {
        logic [127:0] a;
        logic [127:0] b;
        logic [127:0] n;
        logic         fld;
        logic         sq;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{a: 128'h12345678_9ABCDEF0_0FEDCBA9_87654321, b: 128'hA5A5A5A5_5A5A5A5A_C3C3C3C3_3C3C3C3D,
          n: 128'hF1E2D3C4_B5A69788_79695A4B_3C2D1E0F, fld: 1'b0, sq: 1'b0},
        '{a: 128'hDEADBEEF_CAFEBABE_01234567_89ABCDEF, b: 128'hDEADBEEF_CAFEBABE_01234567_89ABCDEF,
          n: 128'hF1E2D3C4_B5A69788_79695A4B_3C2D1E0F, fld: 1'b0, sq: 1'b1},
        '{a: 128'hFFFF0000_1234ABCD_00000001_80000000, b: 128'h76543210_FEDCBA98_11112222_33334444,
          n: 128'h80000000_00000000_00000000_00000087, fld: 1'b1, sq: 1'b0},
        '{a: 128'h0F0F1E1E_2D2D3C3C_4B4B5A5A_69697878, b: 128'h0F0F1E1E_2D2D3C3C_4B4B5A5A_69697878,
          n: 128'h80000000_00000000_00000000_00000087, fld: 1'b1, sq: 1'b1},
        '{a: 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFE, b: 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFE,
          n: 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF, fld: 1'b0, sq: 1'b1},
        '{a: 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFE, b: 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFD,
          n: 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF, fld: 1'b0, sq: 1'b0},
        '{a: 128'h0, b: 128'hA5A5A5A5_5A5A5A5A_C3C3C3C3_3C3C3C3D,
          n: 128'hF1E2D3C4_B5A69788_79695A4B_3C2D1E0F, fld: 1'b0, sq: 1'b0},
        '{a: 128'h1, b: 128'h1,
          n: 128'h00000000_00000000_00000001_00000001, fld: 1'b0, sq: 1'b0}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ld_en = 1'b0;
    logic [1:0]     ld_sel = '0;
    logic [AW-1:0]  ld_addr = '0;
    logic [31:0]    ld_data = '0;
    logic           start = 1'b0;
    logic           field = 1'b0;
    logic           square = 1'b0;
    logic           busy;
    logic           done;
    logic [NB-1:0]  result;

    int tests = 0;
    int fails = 0;
    int cycle_count = 0;

    dfmont_mul #(.S(S), .AW(AW)) u_dfmont_mul (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr),
        .ld_data(ld_data), .start(start), .field(field), .square(square),
        .busy(busy), .done(done), .result(result)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cycle_count++;
        if (cycle_count > 100000) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cycle_count);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input logic ok, input string what, input logic [511:0] act, input logic [511:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] bclmul32_lo(input logic [31:0] x, input logic [31:0] y);
        logic [63:0] p = '0;
        for (int b = 0; b < 32; b++) if (y[b]) p = p ^ ({32'b0, x} << b);
        return p[31:0];
    endfunction

    function automatic logic [511:0] bclmul(input logic [511:0] x, input logic [511:0] y);
        logic [511:0] p = '0;
        for (int b = 0; b < 256; b++) if (y[b]) p = p ^ (x << b);
        return p;
    endfunction

    function automatic logic [511:0] pmod(input logic [511:0] v, input logic [127:0] n);
        int d = 0;
        logic [511:0] r = v;
        for (int b = 0; b < 128; b++) if (n[b]) d = b;
        for (int b = 511; b >= d; b--) if (r[b]) r = r ^ ({384'b0, n} << (b - d));
        return r;
    endfunction

    function automatic logic [31:0] kconst_of(input logic [31:0] n0, input logic bin);
        logic [31:0] x;
        if (bin) begin
            x = '0;
            for (int b = 0; b < 32; b++) if (bclmul32_lo(n0, x)[b] != (b == 0)) x[b] = 1'b1;
            return x;
        end
        x = n0;
        for (int t = 0; t < 5; t++) x = x * (32'd2 - n0 * x);
        return -x;
    endfunction

    task automatic load_vec(input vec_t v);
        for (int w = S - 1; w >= 0; w--) begin
            @(negedge clk); ld_en = 1'b1; ld_addr = AW'(w);
            ld_sel = 2'd0; ld_data = v.a[32*w +: 32];
            @(negedge clk); ld_sel = 2'd1; ld_data = v.b[32*w +: 32];
            @(negedge clk); ld_sel = 2'd2; ld_data = v.n[32*w +: 32];
        end
        @(negedge clk); ld_sel = 2'd3; ld_addr = AW'(2); ld_data = kconst_of(v.n[31:0], v.fld);
        @(negedge clk); ld_en = 1'b0;
    endtask

    task automatic run_op(input logic f, input logic q, input logic flip,
                          output int cyc, output logic busy_seen);
        @(negedge clk); field = f; square = q; start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        busy_seen = busy;
        cyc = 0;
        while (!done && cyc < 400) begin
            @(posedge clk); #1;
            cyc++;
            if (flip && cyc == 5) begin field = ~f; square = ~q; end
        end
    endtask

    task automatic check_result(input vec_t v, input string tag);
        logic [511:0] act, exp;
        if (v.fld) begin
            act = pmod({384'b0, result} << 128, v.n);
            exp = pmod(bclmul({384'b0, v.a}, {384'b0, v.b}), v.n);
        end else begin
            act = ({384'b0, result} << 128) % {384'b0, v.n};
            exp = ({384'b0, v.a} * {384'b0, v.b}) % {384'b0, v.n};
            check(result < v.n, {tag, " reduced below N"}, {384'b0, result}, {384'b0, v.n});
        end
        check(act == exp, {tag, " residue"}, act, exp);
    endtask

    initial begin
        int cyc;
        logic bs;
        repeat (3) @(posedge clk);
        #1;
        check(!busy && !done && result == '0, "R2 reset state", {509'b0, busy, done, |result}, '0);
        @(negedge clk); rst_n = 1'b1;

        for (int t = 0; t < 8; t++) begin
            load_vec(VECS[t]);
            run_op(VECS[t].fld, VECS[t].sq, 1'b0, cyc, bs);
            check(bs, "R2 busy after start", {511'b0, bs}, 512'd1);
            if (VECS[t].fld)
                check_result(VECS[t], VECS[t].sq ? "R1 R4 R6 binary square" : "R1 R4 binary multiply");
            else if (t == 4 || t == 5)
                check_result(VECS[t], VECS[t].sq ? "R7 R6 carry square" : "R7 carry multiply");
            else
                check_result(VECS[t], VECS[t].sq ? "R1 R3 R6 prime square" : "R1 R3 prime multiply");
            if (VECS[t].sq)
                check(cyc < MUL_CYC, "R6 square shorter", 512'(cyc), 512'(MUL_CYC));
            else
                check(cyc == MUL_CYC, "R5 multiply latency", 512'(cyc), 512'(MUL_CYC));
        end

        repeat (5) @(posedge clk);
        #1;
        check(done && !busy, "R2 done held while idle", {510'b0, done, busy}, 512'd2);

        load_vec(VECS[0]);
        run_op(1'b0, 1'b0, 1'b1, cyc, bs);
        check_result(VECS[0], "R8 mode flipped mid-run");
        check(cyc == MUL_CYC, "R8 latency after flip", 512'(cyc), 512'(MUL_CYC));

        load_vec(VECS[3]);
        run_op(1'b1, 1'b1, 1'b1, cyc, bs);
        check_result(VECS[3], "R8 R4 binary square flipped");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule